// File: doc/BRIEF.md
# Branch Direction Predictor Table

This block predicts whether a conditional branch will be taken. It holds one small state entry per table slot. The slot for a branch is picked only by a field of low-order bits of the branch address, and no tag is stored. The fetch stage presents a PC on the lookup port and gets a taken/not-taken guess back in the same cycle. The execute stage later reports each resolved branch on the update port. That report carries the branch PC, the real outcome, the compiler's static hint and a flag saying the earlier guess was wrong.

A parameter chooses how wide each entry is. A one-bit entry simply remembers the last outcome. A two-bit entry is a saturating counter, which gives the entry hysteresis.

A run-time enable turns on a damping mode. In this mode, a corrective write that would flip an entry's predicted direction is sometimes thrown away. The decision uses a free-running pseudo-random sequence. A write that contradicts the static hint is discarded more often than one that matches it. This helps an entry keep a branch's usual direction when a rare outcome shows up.

Top module: `dirpred_table`

## Requirements
- R1: After reset every entry predicts not-taken: a one-bit entry holds 0 and a two-bit entry holds 01 (weak not-taken).
- R2: The entry is selected by PC bits [IDX_W+1:2], where IDX_W = log2(DEPTH) (6 for the default 64 entries). PCs that match in those bits share one entry. PCs that differ in them do not disturb each other. The contents change only on the clock edge that ends a cycle with an accepted update.
- R3: With one-bit entries, the prediction equals the most recent outcome written to that entry.
- R4: With one-bit entries, a loop branch that was taken four times and then fell through, and that has been run before, is mispredicted twice per run: on its first iteration and on its exit.
- R5: A two-bit entry counts up on a taken outcome and down on a not-taken outcome, saturating at 00 and 11. Its predicted direction is bit 1: 00 and 01 mean not-taken, 10 and 11 mean taken.
- R6: A two-bit entry in a strong state (00 or 11) keeps its predicted direction after one contrary outcome. The same warmed loop is therefore mispredicted only once per run, on its exit.
- R7: When a lookup and an update select the same entry in one cycle, the lookup returns the value held before that update.
- R8: While drop_en is 0, every update is written.
- R9: While drop_en is 1, an update is discarded when three things hold together: up_mispred is 1, the new entry value would change the predicted direction, and the low 8 bits of the random state are below a threshold. The threshold is 96 when up_taken differs from up_hint, and 16 when they match. up_hint = 1 means the static guess is taken.
- R10: An update is never discarded when up_mispred is 0 or when the new value keeps the predicted direction.
- R11: The random state is a 16-bit register. It resets to 16'hACE1 and advances on every update (up_valid = 1), and only then, to {s[14:0], s[15]^s[13]^s[12]^s[10]}. The drop decision uses the value held before the advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_pc | input | PC_W | Fetch PC to look up |
| lk_taken | output | 1 | Predicted direction for lk_pc (1 = taken) |
| up_valid | input | 1 | A resolved branch is reported this cycle |
| up_pc | input | PC_W | PC of the resolved branch |
| up_taken | input | 1 | Actual outcome (1 = taken) |
| up_hint | input | 1 | Static prediction hint (1 = taken) |
| up_mispred | input | 1 | The earlier prediction for this branch was wrong |
| drop_en | input | 1 | Enables random discard of direction-changing writes |

## Verification
A corrupted entry shows up at lk_taken on the first lookup of any PC that aliases to it, in the same cycle. This means every lookup compared against a bench model catches it at once. A wrong random state or a wrong drop threshold stays hidden until damping is enabled and a direction-changing mispredict arrives. After that, one lost or spurious write shows as a flipped prediction on the next lookup of that entry. The bench therefore spends a long mixed stretch on a few aliasing entries, with damping toggled, so that such updates occur often.

// File: rtl/dirpred_pkg.sv
`timescale 1ns/1ps
package dirpred_pkg;
  localparam int RND_W = 16;
  localparam logic [1:0] CTR_SNT = 2'b00;
  localparam logic [1:0] CTR_WNT = 2'b01;
  localparam logic [1:0] CTR_WT  = 2'b10;
  localparam logic [1:0] CTR_ST  = 2'b11;
endpackage

// File: rtl/dirpred_lfsr.sv
`timescale 1ns/1ps
module dirpred_lfsr
  import dirpred_pkg::*;
#(
  parameter logic [RND_W-1:0] SEED = 16'hACE1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  output logic [RND_W-1:0] state
);
  logic [RND_W-1:0] state_q;
  logic [RND_W-1:0] state_d;
  logic             fb;

  assign fb = state_q[15] ^ state_q[13] ^ state_q[12] ^ state_q[10];

  always_comb begin
    state_d = state_q;
    if (adv) state_d = {state_q[RND_W-2:0], fb};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= SEED;
    else        state_q <= state_d;
  end

  assign state = state_q;
endmodule

// File: rtl/dirpred_ctr_next.sv
`timescale 1ns/1ps
module dirpred_ctr_next #(
  parameter int EB = 2
) (
  input  logic [EB-1:0] cur,
  input  logic          taken,
  output logic [EB-1:0] nxt
);
  if (EB == 1) begin : g_last
    assign nxt = taken;
  end else begin : g_sat
    always_comb begin
      nxt = cur;
      if (taken && (cur != {EB{1'b1}}))      nxt = cur + 1'b1;
      else if (!taken && (cur != {EB{1'b0}})) nxt = cur - 1'b1;
    end
  end
endmodule

// File: rtl/dirpred_drop_gate.sv
`timescale 1ns/1ps
module dirpred_drop_gate #(
  parameter int THR_W        = 8,
  parameter int THR_AGREE    = 16,
  parameter int THR_DISAGREE = 96
) (
  input  logic             drop_en,
  input  logic             up_valid,
  input  logic             up_mispred,
  input  logic             flips,
  input  logic             up_taken,
  input  logic             up_hint,
  input  logic [THR_W-1:0] rnd,
  output logic             drop
);
  logic [THR_W-1:0] thr;
  logic             eligible;

  assign thr      = (up_taken != up_hint) ? THR_W'(THR_DISAGREE) : THR_W'(THR_AGREE);
  assign eligible = drop_en & up_valid & up_mispred & flips;
  assign drop     = eligible & (rnd < thr);
endmodule

// File: rtl/dirpred_table.sv
`timescale 1ns/1ps
module dirpred_table
  import dirpred_pkg::*;
#(
  parameter int PC_W         = 32,
  parameter int DEPTH        = 64,
  parameter int ENTRY_BITS   = 2,
  parameter int PC_LSB       = 2,
  parameter int THR_W        = 8,
  parameter int THR_AGREE    = 16,
  parameter int THR_DISAGREE = 96,
  parameter logic [15:0] RND_SEED = 16'hACE1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PC_W-1:0] lk_pc,
  output logic            lk_taken,
  input  logic            up_valid,
  input  logic [PC_W-1:0] up_pc,
  input  logic            up_taken,
  input  logic            up_hint,
  input  logic            up_mispred,
  input  logic            drop_en
);
  localparam int IDX_W = $clog2(DEPTH);
  localparam int EB    = ENTRY_BITS;
  localparam logic [EB-1:0] RST_VAL = (EB == 2) ? EB'(CTR_WNT) : '0;

  logic [IDX_W-1:0]    lk_idx;
  logic [IDX_W-1:0]    up_idx;
  logic [EB*DEPTH-1:0] tbl_flat;
  logic [EB-1:0]       lk_ent;
  logic [EB-1:0]       cur_ent;
  logic [EB-1:0]       nxt_val;
  logic                flips;
  logic                drop;
  logic                we;
  logic [RND_W-1:0]    lfsr_q;
  logic                unused_pc_bits;
  logic                unused_rnd_bits;

  assign lk_idx = lk_pc[PC_LSB +: IDX_W];
  assign up_idx = up_pc[PC_LSB +: IDX_W];
  assign unused_pc_bits  = ^{lk_pc, up_pc};
  assign unused_rnd_bits = ^lfsr_q;

  assign lk_ent   = tbl_flat[lk_idx*EB +: EB];
  assign lk_taken = lk_ent[EB-1];
  assign cur_ent  = tbl_flat[up_idx*EB +: EB];

  dirpred_ctr_next #(.EB(EB)) u_next (
    .cur   (cur_ent),
    .taken (up_taken),
    .nxt   (nxt_val)
  );

  assign flips = nxt_val[EB-1] != cur_ent[EB-1];

  dirpred_lfsr #(.SEED(RND_SEED)) u_rnd (
    .clk   (clk),
    .rst_n (rst_n),
    .adv   (up_valid),
    .state (lfsr_q)
  );

  dirpred_drop_gate #(
    .THR_W        (THR_W),
    .THR_AGREE    (THR_AGREE),
    .THR_DISAGREE (THR_DISAGREE)
  ) u_gate (
    .drop_en    (drop_en),
    .up_valid   (up_valid),
    .up_mispred (up_mispred),
    .flips      (flips),
    .up_taken   (up_taken),
    .up_hint    (up_hint),
    .rnd        (lfsr_q[THR_W-1:0]),
    .drop       (drop)
  );

  assign we = up_valid & ~drop;

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    logic          wr_i;
    logic [EB-1:0] ent_q;
    logic [EB-1:0] ent_d;

    assign wr_i = we && (up_idx == IDX_W'(i));

    always_comb begin
      ent_d = ent_q;
      if (wr_i) ent_d = nxt_val;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ent_q <= RST_VAL;
      else        ent_q <= ent_d;
    end

    assign tbl_flat[i*EB +: EB] = ent_q;
  end
endmodule

// File: rtl/dirpred_checker.sv
`timescale 1ns/1ps
module dirpred_checker #(
  parameter int IDX_W = 6,
  parameter int EB    = 2
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     up_valid,
  input logic                     up_taken,
  input logic                     up_mispred,
  input logic                     drop_en,
  input logic                     drop,
  input logic [IDX_W-1:0]         up_idx,
  input logic [EB-1:0]            cur_ent,
  input logic [EB-1:0]            nxt_val,
  input logic [15:0]              lfsr_q,
  input logic [EB*(1<<IDX_W)-1:0] tbl_flat
);
  logic [IDX_W-1:0] idx_q;
  logic [EB-1:0]    ent_after;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        idx_q <= '0;
    else if (up_valid) idx_q <= up_idx;
  end

  assign ent_after = tbl_flat[idx_q*EB +: EB];

  AST_IDLE_TABLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !up_valid |=> $stable(tbl_flat)); // R2
  AST_NO_DROP_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !drop_en |-> !drop); // R8
  AST_KEEP_DIR_NOT_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (up_valid && (nxt_val[EB-1] == cur_ent[EB-1])) |-> !drop); // R10
  AST_NO_MISPRED_NOT_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (up_valid && !up_mispred) |-> !drop); // R10
  AST_RND_ADVANCES: assert property (@(posedge clk) disable iff (!rst_n)
    up_valid |=> (lfsr_q != $past(lfsr_q))); // R11
  AST_RND_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !up_valid |=> $stable(lfsr_q)); // R11
  AST_RND_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    lfsr_q != 16'h0); // R11

  if (EB == 1) begin : g_one
    AST_ONE_BIT_LAST: assert property (@(posedge clk) disable iff (!rst_n)
      (up_valid && !drop) |=> (ent_after[0] == $past(up_taken))); // R3
  end else begin : g_two
    AST_STRONG_T_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (up_valid && cur_ent == 2'b11) |=> ent_after[1]); // R6
    AST_STRONG_NT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (up_valid && cur_ent == 2'b00) |=> !ent_after[1]); // R6
    AST_SAT_TOP: assert property (@(posedge clk) disable iff (!rst_n)
      (up_valid && cur_ent == 2'b11 && up_taken) |=> (ent_after == 2'b11)); // R5
  end
endmodule

bind dirpred_table dirpred_checker #(.IDX_W(IDX_W), .EB(EB)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .up_valid   (up_valid),
  .up_taken   (up_taken),
  .up_mispred (up_mispred),
  .drop_en    (drop_en),
  .drop       (drop),
  .up_idx     (up_idx),
  .cur_ent    (cur_ent),
  .nxt_val    (nxt_val),
  .lfsr_q     (lfsr_q),
  .tbl_flat   (tbl_flat)
);

// File: tb/sim_dirpred_table.sv
`timescale 1ns/1ps
module sim_dirpred_table;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] lk_pc, up_pc;
  logic        up_valid, up_taken, up_hint, up_mispred, drop_en;
  logic        lk2, lk1;

  int n_run = 0, n_fail = 0;
  int n_drop = 0, n_elig = 0;
  logic [1:0]  m2 [64];
  logic        m1 [64];
  logic [15:0] m_rnd;
  logic        p2, p1;

  always #2.5 clk = ~clk;

  dirpred_table #(.ENTRY_BITS(2)) u0 (
    .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .lk_taken(lk2),
    .up_valid(up_valid), .up_pc(up_pc), .up_taken(up_taken),
    .up_hint(up_hint), .up_mispred(up_mispred), .drop_en(drop_en));

  dirpred_table #(.ENTRY_BITS(1)) u1 (
    .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .lk_taken(lk1),
    .up_valid(up_valid), .up_pc(up_pc), .up_taken(up_taken),
    .up_hint(up_hint), .up_mispred(up_mispred), .drop_en(drop_en));

  function automatic logic [1:0] sat_next(logic [1:0] c, logic t);
    if (t)  return (c == 2'b11) ? c : c + 2'd1;
    return (c == 2'b00) ? c : c - 2'd1;
  endfunction

  function automatic logic drop_rule(logic den, logic mis, logic flip,
                                     logic t, logic h, logic [7:0] r);
    int thr;
    thr = (t != h) ? 96 : 16;
    return den && mis && flip && (int'(r) < thr);
  endfunction

  task automatic chk(string req, logic act, logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0b expected %0b", req, act, exp);
    end
  endtask

  // One cycle: drive at negedge, compare lookup vs model, update model.
  task automatic step(string req, logic v, logic [31:0] upc, logic t, logic h,
                      logic mis, logic den, logic [31:0] lpc);
    logic [5:0] ui, li;
    logic [1:0] n2;
    logic       n1, d2, d1;
    @(negedge clk);
    up_valid = v; up_pc = upc; up_taken = t; up_hint = h;
    up_mispred = mis; drop_en = den; lk_pc = lpc;
    #1;
    li = lpc[7:2];
    ui = upc[7:2];
    p2 = lk2; p1 = lk1;
    chk({req, " u0"}, lk2, m2[li][1]);
    chk({req, " u1"}, lk1, m1[li]);
    if (v) begin
      n2 = sat_next(m2[ui], t);
      n1 = t;
      d2 = drop_rule(den, mis, n2[1] != m2[ui][1], t, h, m_rnd[7:0]);
      d1 = drop_rule(den, mis, n1 != m1[ui], t, h, m_rnd[7:0]);
      if (den && mis && (n2[1] != m2[ui][1])) n_elig++;
      if (d2) n_drop++;
      if (!d2) m2[ui] = n2;
      if (!d1) m1[ui] = n1;
      m_rnd = {m_rnd[14:0], m_rnd[15] ^ m_rnd[13] ^ m_rnd[12] ^ m_rnd[10]};
    end
  endtask

  initial begin
    #(5.0 * 200000);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int mis1, mis2;
    for (int i = 0; i < 64; i++) begin m2[i] = 2'b01; m1[i] = 1'b0; end
    m_rnd = 16'hACE1;
    rst_n = 1'b0; up_valid = 0; up_pc = 0; up_taken = 0; up_hint = 0;
    up_mispred = 0; drop_en = 0; lk_pc = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1: every entry not-taken after reset
    for (int i = 0; i < 64; i++) begin
      step("R1", 0, 0, 0, 0, 0, 0, 32'(i) << 2);
      chk("R1 explicit", p2 | p1, 1'b0);
    end

    // R7: same-cycle hit returns old value
    step("R7", 1, 32'h0C, 1, 0, 1, 0, 32'h0C);
    chk("R7 old u0", p2, 1'b0);
    chk("R7 old u1", p1, 1'b0);
    step("R7", 0, 0, 0, 0, 0, 0, 32'h0C);
    chk("R7 new u0", p2, 1'b1);
    chk("R7 new u1", p1, 1'b1);

    // R2: aliasing through high PC bits, independence of neighbours
    step("R2", 0, 0, 0, 0, 0, 0, 32'h0C + 32'h100);
    chk("R2 alias", p2, 1'b1);
    step("R2", 0, 0, 0, 0, 0, 0, 32'h10);
    chk("R2 neighbour", p2 | p1, 1'b0);

    // R5 / R3 / R6 on entry 5
    repeat (4) step("R5", 1, 32'h14, 0, 0, 1, 0, 32'h14);
    step("R5", 1, 32'h14, 1, 0, 1, 0, 32'h14);
    step("R5", 0, 0, 0, 0, 0, 0, 32'h14);
    chk("R5 from 00 one T", p2, 1'b0);
    chk("R3 last outcome", p1, 1'b1);
    step("R5", 1, 32'h14, 1, 0, 1, 0, 32'h14);
    step("R5", 0, 0, 0, 0, 0, 0, 32'h14);
    chk("R5 second T", p2, 1'b1);
    repeat (3) step("R5", 1, 32'h14, 1, 0, 1, 0, 32'h14);
    step("R6", 1, 32'h14, 0, 0, 1, 0, 32'h14);
    step("R6", 0, 0, 0, 0, 0, 0, 32'h14);
    chk("R6 strong keeps", p2, 1'b1);
    chk("R3 flipped", p1, 1'b0);

    // R4 / R6: warmed loop branch, entry 16
    mis1 = 0; mis2 = 0;
    for (int run = 0; run < 3; run++) begin
      for (int it = 0; it < 5; it++) begin
        logic t;
        t = (it < 4);
        step("R4", 1, 32'h40, t, 1, 1, 0, 32'h40);
        if (run > 0) begin
          if (p1 != t) mis1++;
          if (p2 != t) mis2++;
        end
      end
    end
    n_run++;
    if (mis1 != 4) begin n_fail++; $display("FAIL R4: actual %0d expected %0d", mis1, 4); end
    n_run++;
    if (mis2 != 2) begin n_fail++; $display("FAIL R6: actual %0d expected %0d", mis2, 2); end

    // R10: no mispred flag -> never dropped even with damping on
    step("R10", 1, 32'h50, 1, 0, 0, 1, 32'h50);
    step("R10", 0, 0, 0, 0, 0, 0, 32'h50);
    chk("R10 kept u0", p2, 1'b1);
    chk("R10 kept u1", p1, 1'b1);

    // Mixed random phase: few aliasing entries, damping toggled (R8 R9 R11)
    void'($urandom(32'd1234));
    for (int k = 0; k < 4000; k++) begin
      logic [31:0] a, b;
      logic den;
      a = {24'($urandom_range(0, 3)), 2'($urandom_range(0, 3)), 6'b0} | 32'((($urandom_range(0,3)) << 2));
      b = {24'($urandom_range(0, 3)), 8'($urandom_range(0, 3) << 2)};
      den = ($urandom_range(0, 3) != 0);
      step(den ? "R9" : "R8", ($urandom_range(0, 9) < 8), a,
           1'($urandom), 1'($urandom), 1'($urandom), den, b);
    end
    n_run++;
    if (n_drop == 0) begin n_fail++; $display("FAIL R9: actual %0d drops expected >0", n_drop); end
    n_run++;
    if (n_drop >= n_elig) begin n_fail++; $display("FAIL R9: actual %0d drops expected <%0d", n_drop, n_elig); end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule